// File: doc/BRIEF.md
# Two-Stage Serial Bit Clock Divider

This block derives the bit clock of a serial shift engine from the system clock. The division has two stages. An even prescaler covers 2 to 254. A rate counter behind it covers 0 to 255. The bit clock therefore runs at the system clock divided by prescale × (1 + rate). The range runs from half the system clock down to the system clock divided by 254 × 256.

Besides the clock itself, the block gives the shift engine two single-cycle strobes. The leading strobe marks each transition away from the idle level. The trailing strobe marks each return to it.

A frame starts when `run` rises. At that moment the block captures the divider settings and the idle level. These stay fixed until `run` falls, so a setting written during a frame applies only to the next one. While `run` is low, the counters are cleared and the clock rests at the idle level.

Top module: `serial_clk_div`

## Requirements
- R1: Each half period of `sclk` lasts (P/2) × (1 + N) system clocks. P is the effective prescale and N is the rate value. The first transition is registered by the clock edge (P/2)×(1+N) edges after the edge that first samples `run` high.
- R2: Bit 0 of `prescale` is ignored, so an odd value behaves as the even value one below it.
- R3: A `prescale` value of 0 or 1 behaves as 2.
- R4: With prescale 2 and rate 0, `sclk` changes on every system clock edge. This is half the system clock rate.
- R5: With prescale 254 and rate 255, each half period lasts 32512 system clocks. This is the system clock divided by 65024 per bit.
- R6: While `run` is low, `sclk` equals the current `idle_high` input and neither strobe is asserted. This level is visible from the cycle after `run` is first sampled low.
- R7: `lead_stb` is high for exactly the one cycle in which `sclk` has just left the idle level. `trail_stb` is high for exactly the one cycle in which `sclk` has just returned to it. The two are never high together, and they alternate starting with `lead_stb`.
- R8: `prescale`, `rate` and `idle_high` are captured when a frame starts. Changes to them while `run` stays high have no effect on timing or polarity.
- R9: After `run` falls and rises again, counting restarts from zero with the newly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High for the duration of a frame; the rising edge captures settings |
| prescale | input | 8 | Even prescale divisor (bit 0 ignored, values below 2 read as 2) |
| rate | input | 8 | Rate counter value N, divisor factor 1 + N |
| idle_high | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial bit clock |
| lead_stb | output | 1 | One-cycle strobe on each transition away from idle |
| trail_stb | output | 1 | One-cycle strobe on each return to idle |

## Verification
Two situations are the hardest to reach from the ports. The first is the slowest setting, where a single half period lasts over thirty thousand cycles. The scoreboard checks it by predicting the exact cycle of each strobe rather than waiting on the clock. The second is a change of settings while a frame is running, which must leave it untouched. That stimulus rewrites prescale, rate and idle level a few cycles into a frame. It then expects edge times and levels that still follow the values captured at its start. Disabling a frame while the clock is high checks both the return to idle and the clean restart that follows.

// File: rtl/serial_clk_div.sv
module serial_clk_div #(
  parameter int PW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] prescale,
  input  logic [RW-1:0] rate,
  input  logic          idle_high,
  output logic          sclk,
  output logic          lead_stb,
  output logic          trail_stb
);
  localparam int HW = PW - 1;
  localparam logic [HW-1:0] ONE_H = 1;
  localparam logic [RW-1:0] ONE_R = 1;

  logic          active, pol_q, phase, lead_q, trail_q;
  logic [HW-1:0] half_q, pre_cnt;
  logic [RW-1:0] rate_q, rate_cnt;

  wire [HW-1:0] half_in = (prescale[PW-1:1] == '0) ? ONE_H : prescale[PW-1:1];
  wire pre_wrap  = (pre_cnt == half_q - ONE_H);
  wire rate_wrap = (rate_cnt == rate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      pol_q    <= 1'b0;
      phase    <= 1'b0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
      half_q   <= ONE_H;
      rate_q   <= '0;
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (!run) begin
      active   <= 1'b0;
      phase    <= 1'b0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (!active) begin
      active   <= 1'b1;
      pol_q    <= idle_high;
      half_q   <= half_in;
      rate_q   <= rate;
      phase    <= 1'b0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (pre_wrap) begin
        pre_cnt <= '0;
        if (rate_wrap) begin
          rate_cnt <= '0;
          phase    <= ~phase;
          lead_q   <= ~phase;
          trail_q  <= phase;
        end else begin
          rate_cnt <= rate_cnt + ONE_R;
        end
      end else begin
        pre_cnt <= pre_cnt + ONE_H;
      end
    end
  end

  assign sclk      = active ? (pol_q ^ phase) : idle_high;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;
endmodule

module serial_clk_div_props (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic idle_high,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  logic last_lead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          last_lead <= 1'b0;
    else if (!run)       last_lead <= 1'b0;
    else if (lead_stb)   last_lead <= 1'b1;
    else if (trail_stb)  last_lead <= 1'b0;
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  a_r7_trail_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> last_lead);

  a_r7_lead_after_trail: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> !last_lead);

  a_r7_strobe_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb || trail_stb) |-> (sclk != $past(sclk)));

  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == idle_high && !lead_stb && !trail_stb));

  a_r1_toggle_only_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(run, 2) && sclk != $past(sclk)) |-> (lead_stb || trail_stb));
endmodule

bind serial_clk_div serial_clk_div_props u_props (
  .clk(clk), .rst_n(rst_n), .run(run), .idle_high(idle_high),
  .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/serial_clk_div_test.sv
module serial_clk_div_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] prescale = 8'd2;
  logic [7:0] rate = 8'd0;
  logic       idle_high = 1'b0;
  logic       sclk, lead_stb, trail_stb;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int exp_cyc[$];
  int exp_kind[$];
  int exp_lvl[$];
  string exp_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_clk_div uut (
    .clk(clk), .rst_n(rst_n), .run(run), .prescale(prescale), .rate(rate),
    .idle_high(idle_high), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops predicted strobes and compares cycle, kind and level (R7)
  always @(negedge clk) begin
    if (rst_n && (lead_stb || trail_stb)) begin
      check(!(lead_stb && trail_stb), "R7 both strobes", 1, 0);
      if (exp_cyc.size() == 0) begin
        check(1'b0, "R6 unexpected strobe", cyc, -1);
      end else begin
        int ec, ek, el;
        string tg;
        ec = exp_cyc.pop_front();
        ek = exp_kind.pop_front();
        el = exp_lvl.pop_front();
        tg = exp_tag.pop_front();
        check(cyc == ec, {tg, " strobe cycle"}, cyc, ec);
        check(int'(lead_stb) == ek, {tg, " R7 strobe kind"}, int'(lead_stb), ek);
        check(int'(sclk) == el, {tg, " R7 sclk level"}, int'(sclk), el);
      end
    end
  end

  // Driver: starts a frame, predicts its edges, optionally rewrites settings mid-frame
  task automatic run_frame(input int ps, input int rt, input bit pol, input int n_edges,
                           input bit mid_change, input string tag);
    int half, h, n, last;
    @(negedge clk);
    prescale  = ps[7:0];
    rate      = rt[7:0];
    idle_high = pol;
    run       = 1'b1;
    n = cyc;
    half = ps / 2;
    if (half == 0) half = 1;
    h = half * (rt + 1);
    for (int k = 1; k <= n_edges; k++) begin
      exp_cyc.push_back(n + 1 + k * h);
      exp_kind.push_back(k % 2);
      exp_lvl.push_back((k % 2) ? int'(!pol) : int'(pol));
      exp_tag.push_back(tag);
    end
    last = n + 1 + n_edges * h;
    if (mid_change) begin
      repeat (3) @(negedge clk);
      prescale  = 8'd2;
      rate      = 8'd0;
      idle_high = !pol;
    end
    while (cyc < last) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(sclk == idle_high, "R6 idle level after stop", int'(sclk), int'(idle_high));
    check(!lead_stb && !trail_stb, "R6 no strobe after stop", int'(lead_stb | trail_stb), 0);
    check(exp_cyc.size() == 0, {tag, " missing strobes"}, exp_cyc.size(), 0);
    exp_cyc.delete(); exp_kind.delete(); exp_lvl.delete(); exp_tag.delete();
    idle_high = !idle_high;
    @(negedge clk);
    check(sclk == idle_high, "R6 idle follows input", int'(sclk), int'(idle_high));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sclk == 1'b0 && !lead_stb && !trail_stb, "R6 reset state", int'(sclk), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk == idle_high, "R6 idle before first frame", int'(sclk), int'(idle_high));

    run_frame(2,   0,   1'b0, 6, 1'b0, "R4");
    run_frame(3,   1,   1'b0, 4, 1'b0, "R2");
    run_frame(0,   2,   1'b1, 4, 1'b0, "R3");
    run_frame(1,   0,   1'b0, 2, 1'b0, "R3");
    run_frame(10,  4,   1'b1, 4, 1'b1, "R1 R8");
    run_frame(6,   3,   1'b0, 3, 1'b0, "R6");
    run_frame(6,   3,   1'b0, 4, 1'b0, "R9");
    run_frame(254, 255, 1'b0, 2, 1'b0, "R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule